// File: doc/BRIEF.md
# DMA Request-to-Channel Router

This block sits between the peripheral request lines of a chip and the channels of a multi-channel DMA engine. Each peripheral request input has a programmable map entry that says whether the request is routed, and to which channel. Software programs the entries through a 32-bit register port. The entries are reached through two separate address windows.

The request inputs are synchronised into the clock domain and edge-detected before they are routed. Each channel keeps the level of the request most recently routed to it. When a routed request changes, the block emits one-cycle event pulses to the channel status logic. A rise on a channel that was idle signals request-after-stop. Every other routed change clears that condition. A fall on a channel that was active signals end-of-receive.

If several requests that share a channel change in the same cycle, the highest-numbered one decides the outcome. A map write that names a channel the engine does not have is refused, and an error pulse is raised.

Top module: `dma_req_router`

## Requirements
- R1: After reset every map entry reads as zero, which means not routed. All channel levels, event pulses and the error output are low.
- R2: A map entry holds a routing-valid flag in data bit 7 and a channel number in bits 4:0. A read returns those bits and zero in all other bit positions. Write data in other bits is discarded.
- R3: Entry i for i below 64 is at address 0x100 + 4*i. Entry i for i from 64 to NUM_REQ-1 is at 0x1100 + 4*(i-64). Writes to any other address, including misaligned ones, store nothing, and reads there return zero. The read data is combinational on the address.
- R4: A change on a request whose entry has the valid flag clear causes no channel level change and no event.
- R5: A routed request rising on a channel whose level is low sets that channel level high and pulses `ras_set_o` for that channel for one cycle. The outputs respond on the third rising clock edge after the input change.
- R6: Any other routed change pulses `ras_clr_o` for the channel for one cycle. This covers a rise while the channel is already high and any fall.
- R7: A routed request falling while its channel is high drives the channel level low and pulses `eor_set_o` for one cycle. A fall while the channel is already low gives no `eor_set_o`.
- R8: A write to a map entry with the valid flag set and a channel number of NUM_CH or more is refused. The entry keeps its old value and `map_err_o` pulses for one cycle after the write. A write with the valid flag clear is always accepted.
- R9: When several requests routed to the same channel change in the same cycle, the highest-numbered request sets the new channel level and the events. The level follows the last change routed to the channel, even when another request on that channel is still high.
- R10: Routing follows the current map contents. After an entry is rewritten to another channel, later changes of that request act on the new channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_REQ | Peripheral request levels, asynchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| map_err_o | output | 1 | One-cycle pulse after a refused map write |
| ch_req_o | output | NUM_CH | Request level held per channel |
| ras_set_o | output | NUM_CH | Request-after-stop set pulse per channel |
| ras_clr_o | output | NUM_CH | Request-after-stop clear pulse per channel |
| eor_set_o | output | NUM_CH | End-of-receive set pulse per channel |

## Verification
Routing is exercised with several stimulus patterns:

- A lone rise and fall on one channel separates the request-after-stop, clear and end-of-receive pulses and pins the three-edge latency.
- A second request sharing a busy channel shows that the level follows the last change rather than an OR of the inputs.
- Opposite simultaneous edges on a shared channel, applied in both polarities, show that the higher-numbered request wins.
- Requests on invalid or unprogrammed entries, a request mapped through the upper address window and a remapped entry separate address decode and table lookup faults from routing faults.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int unsigned CH_FIELD_W = 5;
  localparam int unsigned VLD_BIT    = 7;

  typedef struct packed {
    logic                  vld;
    logic [CH_FIELD_W-1:0] ch;
  } map_ent_t;
endpackage

// File: rtl/drr_req_sync.sv
module drr_req_sync #(
  parameter int unsigned NUM_REQ = 75
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] lvl_o,
  output logic [NUM_REQ-1:0] edge_o
);
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_bit
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= req_i[r];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign lvl_o[r]  = sync_q;
    assign edge_o[r] = sync_q ^ prev_q;
  end
endmodule

// File: rtl/drr_map_table.sv
module drr_map_table
  import drr_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 75,
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WIN_A_BASE = 'h100,
  parameter int unsigned WIN_B_BASE = 'h1100,
  parameter int unsigned WIN_A_CNT  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              map_err_o,
  output map_ent_t          ent_o [NUM_REQ]
);
  localparam int unsigned IDX_W = $clog2(NUM_REQ);
  localparam int unsigned B_CNT = (NUM_REQ > WIN_A_CNT) ? NUM_REQ - WIN_A_CNT : 0;
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(WIN_A_BASE);
  localparam logic [ADDR_W-1:0] B_BASE = ADDR_W'(WIN_B_BASE);
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(WIN_A_CNT * 4);
  localparam logic [ADDR_W-1:0] B_SPAN = ADDR_W'(B_CNT * 4);

  map_ent_t          ent_q [NUM_REQ];
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] offs_a, offs_b;
  map_ent_t          wr_ent, rd_ent;
  logic              bad_ch, wr_ok, err_nxt, err_q;
  logic              unused_wdata;

  // address decode over the two windows
  always_comb begin
    offs_a = reg_addr_i - A_BASE;
    offs_b = reg_addr_i - B_BASE;
    hit    = 1'b0;
    idx    = '0;
    if (reg_addr_i >= A_BASE && offs_a < A_SPAN && offs_a[1:0] == 2'b00) begin
      hit = 1'b1;
      idx = IDX_W'(offs_a >> 2);
    end else if (reg_addr_i >= B_BASE && offs_b < B_SPAN && offs_b[1:0] == 2'b00) begin
      hit = 1'b1;
      idx = IDX_W'(WIN_A_CNT) + IDX_W'(offs_b >> 2);
    end
  end

  // write qualification and range check
  always_comb begin
    wr_ent.vld = reg_wdata_i[VLD_BIT];
    wr_ent.ch  = reg_wdata_i[CH_FIELD_W-1:0];
    bad_ch     = wr_ent.vld && ({1'b0, wr_ent.ch} >= (CH_FIELD_W+1)'(NUM_CH));
    wr_ok      = reg_wr_i && hit && !bad_ch;
    err_nxt    = reg_wr_i && hit && bad_ch;
  end

  assign unused_wdata = ^{reg_wdata_i[DATA_W-1:VLD_BIT+1], reg_wdata_i[VLD_BIT-1:CH_FIELD_W]};

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_ent
    logic we;
    assign we = wr_ok && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (we) begin
        ent_q[i] <= wr_ent;
      end
    end

    assign ent_o[i] = ent_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_nxt;
    end
  end

  assign map_err_o = err_q;

  // combinational readback
  always_comb begin
    rd_ent      = hit ? ent_q[idx] : '0;
    reg_rdata_o = '0;
    reg_rdata_o[VLD_BIT]          = rd_ent.vld;
    reg_rdata_o[CH_FIELD_W-1:0]   = rd_ent.ch;
  end
endmodule

// File: rtl/drr_chan_route.sv
module drr_chan_route
  import drr_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_REQ-1:0] lvl_i,
  input  logic [NUM_REQ-1:0] edge_i,
  input  map_ent_t          ent_i [NUM_REQ],
  output logic [NUM_CH-1:0] ch_req_o,
  output logic [NUM_CH-1:0] ras_set_o,
  output logic [NUM_CH-1:0] ras_clr_o,
  output logic [NUM_CH-1:0] eor_set_o
);
  logic [NUM_CH-1:0] hit, val;
  logic [NUM_CH-1:0] lvl_q, lvl_nxt;
  logic [NUM_CH-1:0] ras_set_q, ras_clr_q, eor_q;
  logic [NUM_CH-1:0] ras_set_nxt, ras_clr_nxt, eor_nxt;

  // per channel: scan requests in ascending order, the last match wins
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      hit[c] = 1'b0;
      val[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (edge_i[r] && ent_i[r].vld && ent_i[r].ch == CH_FIELD_W'(c)) begin
          hit[c] = 1'b1;
          val[c] = lvl_i[r];
        end
      end
    end
  end

  always_comb begin
    lvl_nxt     = (hit & val) | (~hit & lvl_q);
    ras_set_nxt = hit & val & ~lvl_q;
    ras_clr_nxt = hit & ~(val & ~lvl_q);
    eor_nxt     = hit & ~val & lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      ras_set_q <= '0;
      ras_clr_q <= '0;
      eor_q     <= '0;
    end else begin
      lvl_q     <= lvl_nxt;
      ras_set_q <= ras_set_nxt;
      ras_clr_q <= ras_clr_nxt;
      eor_q     <= eor_nxt;
    end
  end

  assign ch_req_o  = lvl_q;
  assign ras_set_o = ras_set_q;
  assign ras_clr_o = ras_clr_q;
  assign eor_set_o = eor_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import drr_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 75,
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WIN_A_BASE = 'h100,
  parameter int unsigned WIN_B_BASE = 'h1100,
  parameter int unsigned WIN_A_CNT  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               map_err_o,
  output logic [NUM_CH-1:0]  ch_req_o,
  output logic [NUM_CH-1:0]  ras_set_o,
  output logic [NUM_CH-1:0]  ras_clr_o,
  output logic [NUM_CH-1:0]  eor_set_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_REQ-1:0] req_lvl, req_edge;
  map_ent_t           ent [NUM_REQ];

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  drr_req_sync #(.NUM_REQ(NUM_REQ)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (req_i),
    .lvl_o  (req_lvl),
    .edge_o (req_edge)
  );

  drr_map_table #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WIN_A_BASE(WIN_A_BASE), .WIN_B_BASE(WIN_B_BASE), .WIN_A_CNT(WIN_A_CNT)
  ) u_map (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .map_err_o   (map_err_o),
    .ent_o       (ent)
  );

  drr_chan_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lvl_i     (req_lvl),
    .edge_i    (req_edge),
    .ent_i     (ent),
    .ch_req_o  (ch_req_o),
    .ras_set_o (ras_set_o),
    .ras_clr_o (ras_clr_o),
    .eor_set_o (eor_set_o)
  );
endmodule

// File: rtl/drr_checks.sv
module drr_checks #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic              wdata_vld,
  input logic [4:0]        wdata_ch,
  input logic              map_err_o,
  input logic [NUM_CH-1:0] ch_req_o,
  input logic [NUM_CH-1:0] ras_set_o,
  input logic [NUM_CH-1:0] ras_clr_o,
  input logic [NUM_CH-1:0] eor_set_o
);
  p_ras_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_set_o != '0) |-> (((ras_set_o & ~ch_req_o) == '0) && ((ras_set_o & $past(ch_req_o)) == '0)));

  p_level_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_req_o & ~$past(ch_req_o) & ~ras_set_o) == '0));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_set_o & ras_clr_o) == '0) && ((ras_set_o & eor_set_o) == '0));

  p_eor_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_set_o != '0) |-> (((eor_set_o & ch_req_o) == '0) && ((eor_set_o & ~$past(ch_req_o)) == '0)));

  p_level_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ch_req_o & $past(ch_req_o) & ~eor_set_o) == '0));

  p_eor_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((eor_set_o & ~ras_clr_o) == '0));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_err_o |-> ($past(reg_wr_i) && $past(wdata_vld) && ({1'b0, $past(wdata_ch)} >= 6'(NUM_CH))));
endmodule

bind dma_req_router drr_checks #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_i  (reg_wr_i),
  .wdata_vld (reg_wdata_i[7]),
  .wdata_ch  (reg_wdata_i[4:0]),
  .map_err_o (map_err_o),
  .ch_req_o  (ch_req_o),
  .ras_set_o (ras_set_o),
  .ras_clr_o (ras_clr_o),
  .eor_set_o (eor_set_o)
);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb;
  localparam int NUM_REQ = 75;
  localparam int NUM_CH  = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_REQ-1:0] req_i;
  logic               reg_wr_i;
  logic [15:0]        reg_addr_i;
  logic [31:0]        reg_wdata_i;
  logic [31:0]        reg_rdata_o;
  logic               map_err_o;
  logic [NUM_CH-1:0]  ch_req_o, ras_set_o, ras_clr_o, eor_set_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_req_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .map_err_o(map_err_o), .ch_req_o(ch_req_o), .ras_set_o(ras_set_o),
    .ras_clr_o(ras_clr_o), .eor_set_o(eor_set_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ent_addr(input int i);
    return (i < 64) ? 16'(16'h100 + 4 * i) : 16'(16'h1100 + 4 * (i - 64));
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // drive one request, wait for the third edge, sample at the following negedge
  task automatic set_req(input int r, input logic v);
    @(negedge clk);
    req_i[r] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_outs(input string tag, input logic [NUM_CH-1:0] lvl,
                          input logic [NUM_CH-1:0] rs, input logic [NUM_CH-1:0] rc,
                          input logic [NUM_CH-1:0] eo);
    chk({tag, " level"},   32'(ch_req_o),  32'(lvl));
    chk({tag, " ras_set"}, 32'(ras_set_o), 32'(rs));
    chk({tag, " ras_clr"}, 32'(ras_clr_o), 32'(rc));
    chk({tag, " eor_set"}, 32'(eor_set_o), 32'(eo));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(ent_addr(0), d);  chk("R1 entry0 after reset", d, 0);
    rd(ent_addr(74), d); chk("R1 entry74 after reset", d, 0);
    chk_outs("R1 outputs after reset", '0, '0, '0, '0);
    chk("R1 map_err after reset", 32'(map_err_o), 0);
  endtask

  task automatic t_windows;
    logic [31:0] d;
    wr(ent_addr(5), 32'hFFFF_FF83);
    rd(ent_addr(5), d);  chk("R2 field masking entry5", d, 32'h83);
    wr(ent_addr(64), 32'h0000_008A);
    rd(16'h1100, d);     chk("R3 upper window entry64", d, 32'h8A);
    wr(16'h1104, 32'h0000_0081);
    rd(ent_addr(65), d); chk("R3 upper window entry65", d, 32'h81);
    wr(ent_addr(74), 32'h0000_000F);
    rd(16'h1128, d);     chk("R3 last entry74", d, 32'h0F);
    wr(16'h0102, 32'h0000_0081);
    rd(ent_addr(0), d);  chk("R3 misaligned write ignored", d, 0);
    rd(16'h0102, d);     chk("R3 misaligned read zero", d, 0);
    wr(16'h112C, 32'h0000_0081);
    rd(16'h112C, d);     chk("R3 past window end reads zero", d, 0);
    rd(16'h0200, d);     chk("R3 gap reads zero", d, 0);
    // request routed through the upper window
    set_req(64, 1'b1);
    chk_outs("R3 req64 rise on ch10", 16'h0400, 16'h0400, '0, '0);
    set_req(64, 1'b0);
    chk_outs("R3 req64 fall on ch10", '0, '0, 16'h0400, 16'h0400);
  endtask

  task automatic t_rise_fall;
    @(negedge clk);
    req_i[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 no response after two edges", 32'(ch_req_o), 0);
    @(negedge clk);
    chk_outs("R5 rise on idle ch3", 16'h0008, 16'h0008, '0, '0);
    @(negedge clk);
    chk_outs("R5 pulse lasts one cycle", 16'h0008, '0, '0, '0);
    set_req(5, 1'b0);
    chk_outs("R7 fall on busy ch3", '0, '0, 16'h0008, 16'h0008);
    @(negedge clk);
    chk_outs("R7 pulses end", '0, '0, '0, '0);
  endtask

  task automatic t_shared;
    wr(ent_addr(20), 32'h83);
    set_req(5, 1'b1);
    chk_outs("R5 first sharer rises", 16'h0008, 16'h0008, '0, '0);
    set_req(20, 1'b1);
    chk_outs("R6 rise on busy channel", 16'h0008, '0, 16'h0008, '0);
    set_req(5, 1'b0);
    chk_outs("R9 last change drops level", '0, '0, 16'h0008, 16'h0008);
    set_req(20, 1'b0);
    chk_outs("R7 fall on idle channel no eor", '0, '0, 16'h0008, '0);
  endtask

  task automatic t_invalid;
    set_req(74, 1'b1);
    chk_outs("R4 invalid entry rise ignored", '0, '0, '0, '0);
    set_req(40, 1'b1);
    chk_outs("R4 unprogrammed entry rise ignored", '0, '0, '0, '0);
    set_req(74, 1'b0);
    chk_outs("R4 invalid entry fall ignored", '0, '0, '0, '0);
    set_req(40, 1'b0);
  endtask

  task automatic t_range;
    logic [31:0] d;
    wr(ent_addr(64), 32'h90);
    chk("R8 error pulse", 32'(map_err_o), 1);
    @(negedge clk);
    chk("R8 error pulse one cycle", 32'(map_err_o), 0);
    rd(ent_addr(64), d); chk("R8 entry unchanged", d, 32'h8A);
    wr(ent_addr(30), 32'h1F);
    chk("R8 invalid large ch no error", 32'(map_err_o), 0);
    rd(ent_addr(30), d); chk("R8 invalid large ch stored", d, 32'h1F);
    wr(ent_addr(31), 32'h8F);
    chk("R8 top channel no error", 32'(map_err_o), 0);
    rd(ent_addr(31), d); chk("R8 top channel stored", d, 32'h8F);
  endtask

  task automatic t_collide;
    wr(ent_addr(3), 32'h82);
    wr(ent_addr(10), 32'h82);
    set_req(3, 1'b1);
    chk_outs("R9 setup ch2 high", 16'h0004, 16'h0004, '0, '0);
    @(negedge clk);
    req_i[3] = 1'b0; req_i[10] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_outs("R9 higher rise wins", 16'h0004, '0, 16'h0004, '0);
    @(negedge clk);
    req_i[3] = 1'b1; req_i[10] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_outs("R9 higher fall wins", '0, '0, 16'h0004, 16'h0004);
    set_req(3, 1'b0);
    chk_outs("R9 cleanup fall on idle", '0, '0, 16'h0004, '0);
  endtask

  task automatic t_remap;
    wr(ent_addr(5), 32'h87);
    set_req(5, 1'b1);
    chk_outs("R10 remapped rise on ch7", 16'h0080, 16'h0080, '0, '0);
    set_req(5, 1'b0);
    chk_outs("R10 remapped fall on ch7", '0, '0, 16'h0080, 16'h0080);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = '0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_windows();
    t_rise_fall();
    t_shared();
    t_invalid();
    t_range();
    t_collide();
    t_remap();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule